// File: doc/BRIEF.md
# Configuration Register Persistence Controller

This block holds five working configuration registers and decides when their contents are copied, as one image, into a nonvolatile store. The bus front end hands it finished commands: a one-cycle completion pulse, the command code, a read/write flag and the assembled data value. Writes land in the working registers. A mode input selects the copy policy. With mode 0, every register write is followed by a copy. With mode 1, only an explicit persist pulse copies. A write to the device-address register copies in both modes.

While a copy is under way, or while the registers reload from the store after reset, the block raises `busy`. The front end answers every bus request with a NACK during that time. The block also ignores any command that arrives then. The store's write time is fixed by a parameter. A persist pulse that arrives while busy is remembered and served once the current copy ends. Several such pulses merge into one copy. The store keeps its contents through reset.

Top module: `cfg_persist_ctrl`

## Requirements
- R1: After reset is released, `busy` is high and all working registers read zero. On the (RELOAD_CYCLES+1)-th rising edge after release, the registers take the stored image and `busy` falls, both on that same edge.
- R2: A command is applied only when `cmd_done`=1, `cmd_rd`=0 and `busy`=0. Each code writes one register: 08h to the 10-bit level register, 01h to the 10-bit divider, 02h to the 10-bit prescaler, 0Eh to the 5-bit offset and 0Dh to the 5-bit device address. A 10-bit register takes `cmd_data[9:0]` and a 5-bit register takes `cmd_data[4:0]`.
- R3: With `wc_mode`=0, an applied write raises `busy` in the next cycle. `store_we` pulses in the cycle after that.
- R4: With `wc_mode`=1, an applied write to any register other than the device address starts no copy, and `busy` stays low.
- R5: An applied write with code 0Dh starts a copy with the timing of R3, whatever the value of `wc_mode`.
- R6: A `persist_req` pulse while idle starts a copy with the timing of R3, in either mode.
- R7: A read access, or any code outside the five of R2 (37h included), changes no register and starts no copy.
- R8: `store_we` lasts one cycle. While it is high, `snap_bus` equals {level, divider, prescaler, offset, address}, with the level register in bits 39:30 and the address register in bits 4:0, and it matches the working registers.
- R9: `busy` stays high for exactly LATENCY cycles, counted from the `store_we` cycle inclusive, and is low in the next cycle unless a persist request is pending.
- R10: Commands that arrive while `busy` is high leave the working registers unchanged.
- R11: One or more `persist_req` pulses that arrive while busy produce exactly one further copy, which starts right after the current one ends.
- R12: The store keeps the last copied image through reset, and the reload of R1 restores that image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (store contents kept) |
| cmd_done | input | 1 | One-cycle pulse marking a finished bus command |
| cmd_rd | input | 1 | 1 = read access, 0 = write access |
| cmd_code | input | 8 | Command code of the finished command |
| cmd_data | input | 10 | Assembled write value |
| wc_mode | input | 1 | 0 = copy after every write, 1 = copy on persist only |
| persist_req | input | 1 | One-cycle explicit copy request |
| busy | output | 1 | Copy or reload in progress; front end must NACK |
| store_we | output | 1 | One-cycle write strobe toward the store |
| snap_bus | output | 40 | Image presented to the store |
| lvl_q | output | 10 | Level register |
| div_q | output | 10 | Divider register |
| pre_q | output | 10 | Prescaler register |
| ofs_q | output | 5 | Offset register |
| adr_q | output | 5 | Device-address register |

## Verification
The hardest case to reach is a persist request that lands while a copy is in flight, especially when several requests arrive before the counter expires. The bench starts a copy with one pulse, then sends two more pulses on separate cycles inside the busy window. It counts the strobes and measures both busy windows. A second hard case is a reset taken while the working registers differ from the store. The bench writes in mode 1 with no persist, so the two diverge, and then resets to check that the older image comes back.

// File: rtl/cpc_pkg.sv
`timescale 1ns/1ps
package cpc_pkg;
  localparam int WIDE_W   = 10;
  localparam int NARROW_W = 5;
  localparam int CODE_W   = 8;
  localparam int IMAGE_W  = 3 * WIDE_W + 2 * NARROW_W;

  localparam logic [CODE_W-1:0] OP_LVL = 8'h08;
  localparam logic [CODE_W-1:0] OP_OFS = 8'h0E;
  localparam logic [CODE_W-1:0] OP_DIV = 8'h01;
  localparam logic [CODE_W-1:0] OP_PRE = 8'h02;
  localparam logic [CODE_W-1:0] OP_ADR = 8'h0D;

  typedef struct packed {
    logic [WIDE_W-1:0]   lvl;
    logic [WIDE_W-1:0]   div;
    logic [WIDE_W-1:0]   pre;
    logic [NARROW_W-1:0] ofs;
    logic [NARROW_W-1:0] adr;
  } image_t;

  typedef enum logic [2:0] {
    PH_LOAD, PH_FILL, PH_IDLE, PH_ISSUE, PH_WAIT
  } phase_e;
endpackage

// File: rtl/cpc_regfile.sv
`timescale 1ns/1ps
module cpc_regfile
  import cpc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic [WIDE_W-1:0]   wr_data,
  input  logic                load_en,
  input  image_t              load_img,
  output image_t              regs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (load_en) begin
      regs_q <= load_img;
    end else if (wr_en) begin
      case (wr_code)
        OP_LVL:  regs_q.lvl <= wr_data;
        OP_DIV:  regs_q.div <= wr_data;
        OP_PRE:  regs_q.pre <= wr_data;
        OP_OFS:  regs_q.ofs <= wr_data[NARROW_W-1:0];
        OP_ADR:  regs_q.adr <= wr_data[NARROW_W-1:0];
        default: regs_q <= regs_q;
      endcase
    end
  end
endmodule

// File: rtl/cpc_policy.sv
`timescale 1ns/1ps
module cpc_policy
  import cpc_pkg::*;
#(
  parameter int LATENCY       = 4,
  parameter int RELOAD_CYCLES = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   auto_trig,
  input  logic   persist_req,
  input  image_t regs,
  output logic   busy,
  output logic   store_we,
  output image_t snap,
  output logic   load_en
);
  localparam int CNT_MAX = (LATENCY > RELOAD_CYCLES) ? LATENCY : RELOAD_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             pending;
  logic             pend_any;

  always_comb pend_any = pending | persist_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_LOAD;
      cnt      <= CNT_W'(RELOAD_CYCLES - 1);
      busy     <= 1'b1;
      store_we <= 1'b0;
      load_en  <= 1'b0;
      pending  <= 1'b0;
      snap     <= '0;
    end else begin
      store_we <= 1'b0;
      load_en  <= 1'b0;
      case (phase)
        PH_LOAD: begin
          pending <= pend_any;
          if (cnt == '0) begin
            phase   <= PH_FILL;
            load_en <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_FILL: begin
          if (pend_any) begin
            phase   <= PH_ISSUE;
            pending <= 1'b0;
          end else begin
            phase <= PH_IDLE;
            busy  <= 1'b0;
          end
        end
        PH_IDLE: begin
          if (auto_trig || persist_req) begin
            phase <= PH_ISSUE;
            busy  <= 1'b1;
          end
        end
        PH_ISSUE: begin
          store_we <= 1'b1;
          snap     <= regs;
          cnt      <= CNT_W'(LATENCY - 1);
          pending  <= pend_any;
          phase    <= PH_WAIT;
        end
        PH_WAIT: begin
          if (cnt == '0) begin
            if (pend_any) begin
              phase   <= PH_ISSUE;
              pending <= 1'b0;
            end else begin
              phase <= PH_IDLE;
              busy  <= 1'b0;
            end
          end else begin
            cnt     <= cnt - 1'b1;
            pending <= pend_any;
          end
        end
        default: begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cpc_nvstore.sv
`timescale 1ns/1ps
module cpc_nvstore
  import cpc_pkg::*;
#(
  parameter logic [IMAGE_W-1:0] INIT_IMAGE = '0
) (
  input  logic   clk,
  input  logic   we,
  input  image_t din,
  output image_t dout
);
  image_t cells = image_t'(INIT_IMAGE);

  always_ff @(posedge clk) begin
    if (we) cells <= din;
  end

  always_comb dout = cells;
endmodule

// File: rtl/cfg_persist_ctrl.sv
`timescale 1ns/1ps
module cfg_persist_ctrl
  import cpc_pkg::*;
#(
  parameter int LATENCY       = 4,
  parameter int RELOAD_CYCLES = 3,
  parameter logic [IMAGE_W-1:0] INIT_IMAGE =
    {10'h155, 10'h02A, 10'h3C3, 5'h11, 5'h06}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_done,
  input  logic                cmd_rd,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [WIDE_W-1:0]   cmd_data,
  input  logic                wc_mode,
  input  logic                persist_req,
  output logic                busy,
  output logic                store_we,
  output logic [IMAGE_W-1:0]  snap_bus,
  output logic [WIDE_W-1:0]   lvl_q,
  output logic [WIDE_W-1:0]   div_q,
  output logic [WIDE_W-1:0]   pre_q,
  output logic [NARROW_W-1:0] ofs_q,
  output logic [NARROW_W-1:0] adr_q
);
  image_t work_img;
  image_t stored_img;
  image_t snap_img;
  logic   load_en;
  logic   writable;
  logic   wr_en;
  logic   auto_trig;

  always_comb begin
    case (cmd_code)
      OP_LVL, OP_DIV, OP_PRE, OP_OFS, OP_ADR: writable = 1'b1;
      default:                                writable = 1'b0;
    endcase
    wr_en     = cmd_done & ~cmd_rd & ~busy & writable;
    auto_trig = wr_en & (~wc_mode | (cmd_code == OP_ADR));
  end

  cpc_regfile u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_code  (cmd_code),
    .wr_data  (cmd_data),
    .load_en  (load_en),
    .load_img (stored_img),
    .regs_q   (work_img)
  );

  cpc_policy #(
    .LATENCY       (LATENCY),
    .RELOAD_CYCLES (RELOAD_CYCLES)
  ) u_policy (
    .clk         (clk),
    .rst         (rst),
    .auto_trig   (auto_trig),
    .persist_req (persist_req),
    .regs        (work_img),
    .busy        (busy),
    .store_we    (store_we),
    .snap        (snap_img),
    .load_en     (load_en)
  );

  cpc_nvstore #(
    .INIT_IMAGE (INIT_IMAGE)
  ) u_store (
    .clk  (clk),
    .we   (store_we),
    .din  (snap_img),
    .dout (stored_img)
  );

  always_comb begin
    snap_bus = snap_img;
    lvl_q    = work_img.lvl;
    div_q    = work_img.div;
    pre_q    = work_img.pre;
    ofs_q    = work_img.ofs;
    adr_q    = work_img.adr;
  end
endmodule

// File: rtl/cpc_checker.sv
`timescale 1ns/1ps
module cpc_checker
  import cpc_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               store_we,
  input logic [IMAGE_W-1:0] snap_bus,
  input logic [IMAGE_W-1:0] regs,
  input logic               cmd_done,
  input logic               cmd_rd,
  input logic [CODE_W-1:0]  cmd_code,
  input logic               wc_mode,
  input logic               persist_req,
  input logic               load_en
);
  localparam int WIN_W = $clog2(LATENCY + 1) + 1;
  logic [WIN_W-1:0] win;

  always_ff @(posedge clk) begin
    if (rst)                                 win <= '0;
    else if (store_we)                       win <= WIN_W'(1);
    else if (win != '0 && win < WIN_W'(LATENCY)) win <= win + 1'b1;
    else                                     win <= '0;
  end

  assert_reload_busy_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy && regs == '0));

  assert_wc1_no_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !busy && !persist_req && wc_mode &&
     (cmd_rd || cmd_code != OP_ADR)) |=> !busy);

  assert_adr_forces_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !busy && !cmd_rd && cmd_code == OP_ADR) |=> busy ##1 store_we);

  assert_snap_matches_R8: assert property (@(posedge clk) disable iff (rst)
    store_we |-> (snap_bus == regs));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    store_we |=> !store_we);

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (rst)
    store_we |-> busy);

  assert_latency_window_R9: assert property (@(posedge clk) disable iff (rst)
    (win != '0 && win < WIN_W'(LATENCY)) |-> busy);

  assert_frozen_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !load_en) |=> $stable(regs));
endmodule

bind cfg_persist_ctrl cpc_checker #(.LATENCY(LATENCY)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .store_we    (store_we),
  .snap_bus    (snap_bus),
  .regs        (work_img),
  .cmd_done    (cmd_done),
  .cmd_rd      (cmd_rd),
  .cmd_code    (cmd_code),
  .wc_mode     (wc_mode),
  .persist_req (persist_req),
  .load_en     (load_en)
);

// File: tb/cfg_persist_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_persist_ctrl_bench;
  localparam int LAT = 3;
  localparam int RLD = 2;
  localparam logic [39:0] INIT_IMG = {10'h155, 10'h02A, 10'h3C3, 5'h11, 5'h06};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_done = 1'b0, cmd_rd = 1'b0, wc_mode = 1'b0, persist_req = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [9:0] cmd_data = '0;
  logic busy, store_we;
  logic [39:0] snap_bus;
  logic [9:0] lvl_q, div_q, pre_q;
  logic [4:0] ofs_q, adr_q;

  int n_checks = 0, n_fail = 0, strobes = 0;
  logic [39:0] model, store_img;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_persist_ctrl #(.LATENCY(LAT), .RELOAD_CYCLES(RLD)) u_cfg_persist_ctrl (
    .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_rd(cmd_rd),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .wc_mode(wc_mode),
    .persist_req(persist_req), .busy(busy), .store_we(store_we),
    .snap_bus(snap_bus), .lvl_q(lvl_q), .div_q(div_q), .pre_q(pre_q),
    .ofs_q(ofs_q), .adr_q(adr_q));

  always @(negedge clk) if (!rst && store_we) strobes++;

  function automatic logic [39:0] regs_now();
    return {lvl_q, div_q, pre_q, ofs_q, adr_q};
  endfunction

  function automatic bit is_writable(input logic [7:0] c);
    return c == 8'h08 || c == 8'h01 || c == 8'h02 || c == 8'h0E || c == 8'h0D;
  endfunction

  function automatic logic [39:0] apply(input logic [39:0] img, input logic [7:0] c,
                                        input logic [9:0] d);
    logic [39:0] r = img;
    case (c)
      8'h08: r[39:30] = d;
      8'h01: r[29:20] = d;
      8'h02: r[19:10] = d;
      8'h0E: r[9:5]   = d[4:0];
      8'h0D: r[4:0]   = d[4:0];
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic busy_len(input string req);
    int n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
    check(req, "busy length after strobe", n, LAT);
  endtask

  task automatic do_reset(input logic [39:0] exp_img, input string req);
    int n = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "regs zero during reload", regs_now(), 40'h0);
    while (busy && n < 50) begin n++; @(negedge clk); end
    check("R1", "reload busy cycles", n, RLD);
    check(req, "regs after reload", regs_now(), exp_img);
    model = exp_img;
  endtask

  // One command at idle; checks apply, copy decision, strobe, snapshot, busy length.
  task automatic send(input logic [7:0] c, input logic rd, input logic [9:0] d,
                      input string req);
    bit exp_copy;
    cmd_done = 1'b1; cmd_code = c; cmd_rd = rd; cmd_data = d;
    @(negedge clk);
    cmd_done = 1'b0;
    if (!rd && is_writable(c)) model = apply(model, c, d);
    exp_copy = !rd && is_writable(c) && (!wc_mode || c == 8'h0D);
    check(req, "busy after command", busy, exp_copy);
    check("R2", "registers after command", regs_now(), model);
    @(negedge clk);
    check(req, "store strobe", store_we, exp_copy);
    if (exp_copy) begin
      check("R8", "snapshot image", snap_bus, model);
      store_img = model;
      busy_len("R9");
    end
  endtask

  task automatic pulse_persist();
    persist_req = 1'b1;
    @(negedge clk);
    persist_req = 1'b0;
  endtask

  initial begin
    int s0;
    store_img = INIT_IMG;
    repeat (3) @(negedge clk);
    do_reset(INIT_IMG, "R1");

    // Sweep: both modes, both directions, every code.
    for (int w = 0; w < 2; w++) begin
      wc_mode = w[0];
      for (int r = 0; r < 2; r++) begin
        for (int c = 0; c < 256; c++) begin
          logic [9:0] d = 10'((c * 37 + w * 101 + r * 7) ^ 10'h2A5);
          string tag;
          if (r == 1 || !is_writable(8'(c))) tag = "R7";
          else if (c == 8'h0D) tag = "R5";
          else if (w == 1) tag = "R4";
          else tag = "R3";
          send(8'(c), r[0], d, tag);
          wait_idle();
        end
      end
    end

    // R6: explicit persist in both modes.
    for (int w = 0; w < 2; w++) begin
      wc_mode = w[0];
      send(8'h01, 1'b0, 10'(w * 300 + 17), w ? "R4" : "R3");
      wait_idle();
      pulse_persist();
      check("R6", "busy after persist", busy, 1'b1);
      @(negedge clk);
      check("R6", "strobe after persist", store_we, 1'b1);
      check("R6", "persist snapshot", snap_bus, model);
      store_img = model;
      busy_len("R9");
    end

    // R10: command during busy is ignored.
    wc_mode = 1'b0;
    s0 = strobes;
    cmd_done = 1'b1; cmd_code = 8'h08; cmd_rd = 1'b0; cmd_data = 10'h0F0;
    @(negedge clk);
    model = apply(model, 8'h08, 10'h0F0);
    cmd_code = 8'h0E; cmd_data = 10'h01F;
    @(negedge clk);
    cmd_code = 8'h0D; cmd_data = 10'h003;
    @(negedge clk);
    cmd_done = 1'b0;
    store_img = model;
    wait_idle();
    @(negedge clk);
    check("R10", "regs after busy-time writes", regs_now(), model);
    check("R10", "copies from busy-time writes", strobes - s0, 1);

    // R11: two persist pulses during a copy merge into one extra copy.
    wc_mode = 1'b1;
    s0 = strobes;
    pulse_persist();
    @(negedge clk);
    check("R11", "first strobe", store_we, 1'b1);
    pulse_persist();
    @(negedge clk);
    pulse_persist();
    for (int i = 0; i < 20 && !store_we; i++) @(negedge clk);
    check("R11", "second strobe", store_we, 1'b1);
    check("R11", "second snapshot", snap_bus, model);
    busy_len("R11");
    repeat (4) @(negedge clk);
    check("R11", "merged copy count", strobes - s0, 2);
    check("R11", "idle after merge", busy, 1'b0);

    // R12: registers diverge from store, reset restores store image.
    send(8'h02, 1'b0, 10'h2E1, "R4");
    send(8'h0E, 1'b0, 10'h00A, "R4");
    check("R12", "regs diverged from store", regs_now() != store_img, 1'b1);
    do_reset(store_img, "R12");
    send(8'h0D, 1'b0, 10'h019, "R5");
    do_reset(store_img, "R12");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule